// File: doc/BRIEF.md
# Byte-Order Conversion Unit

This unit carries out the byte-order conversion operation of a 64-bit register machine on one destination operand. Each transaction supplies four things: the operand, a class bit that selects 32-bit or 64-bit class semantics, the order bit taken from the opcode, and a 32-bit immediate. The immediate does not carry data. It only gives the width of the conversion. The unit returns the converted value, zero-extended to 64 bits, together with a flag that marks an illegal encoding.

The byte order of the host is fixed when the unit is built, through the parameter `HOST_BIG`. In the 32-bit class the order bit names a target order. If that order matches the host, the bytes keep their order and the value is only truncated to the width. If it differs, the bytes inside the width are reversed. In the 64-bit class the bytes are always reversed.

Transactions enter and leave on valid/ready handshakes. A single registered output slot sits between the two sides. A transaction is taken when `in_valid` and `in_ready` are both high at a clock edge. Its result is offered on the next cycle and stays offered until `out_ready` is high. `in_ready` is high when the slot is empty or is being emptied in the same cycle. An upstream source may therefore hold `in_valid` high for as long as it likes. Back-pressure reaches the source within the same cycle and nothing is dropped.

Top module: `byte_order_unit`

## Requirements
- R1: In the 64-bit class (`cls64`=1, `order_bit`=0), the low N bytes of the operand are reversed unconditionally, where N is the width divided by 8.
- R2: In the 32-bit class, `order_bit`=0 targets little endian and `order_bit`=1 targets big endian. The bytes are reversed only when the target differs from the host order (`HOST_BIG`=0 little, 1 big).
- R3: When no reversal takes place, the result is the operand truncated to the selected width.
- R4: The immediate value 16, 32 or 64 selects the width. Every result bit above that width is zero.
- R5: Any other immediate value sets `illegal` and returns the operand unchanged.
- R6: In the 64-bit class with `order_bit`=1, `illegal` is set and the operand is returned unchanged.
- R7: An accepted transaction appears on `result`/`illegal` with `out_valid` high on the cycle after it is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `result` and `illegal` hold their values and `in_ready` is low.
- R9: After reset `out_valid` is low and `in_ready` is high. The slot stays empty until a transaction is accepted.
- R10: While `out_valid` and `out_ready` are both high, `in_ready` is high, so a new transaction is accepted in the same cycle the old one leaves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Unit can accept a transaction |
| cls64 | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| order_bit | input | 1 | Opcode order bit: 0 little endian, 1 big endian |
| width_imm | input | 32 | Immediate giving the width (16, 32, 64) |
| operand | input | 64 | Destination register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| result | output | 64 | Converted value, zero-extended |
| illegal | output | 1 | Encoding was illegal; result is the operand |

## Verification
The bench builds two copies of the unit: one with `HOST_BIG`=0 and one with `HOST_BIG`=1. Both copies see the same stimulus. With two copies, each value of the order bit in the 32-bit class runs once as a swap and once as a pure truncation. This exercises both branches of the host-order decision for every width. It also shows that the 64-bit class gives the same reversed result whichever host order the unit was built with.

// File: rtl/bo_pkg.sv
package bo_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_W16 = 2'd0,
    SEL_W32 = 2'd1,
    SEL_W64 = 2'd2,
    SEL_BAD = 2'd3
  } width_sel_e;

  localparam int NUM_WIDTHS = 3;
endpackage

// File: rtl/bo_decode.sv
module bo_decode
  import bo_pkg::*;
#(
  parameter int IMM_W    = 32,
  parameter bit HOST_BIG = 1'b0
) (
  input  logic             cls64,
  input  logic             order_bit,
  input  logic [IMM_W-1:0] width_imm,
  output width_sel_e       wsel,
  output logic             do_swap,
  output logic             bad
);
  logic bad_width;

  always_comb begin
    bad_width = 1'b0;
    if (width_imm == IMM_W'(16))      wsel = SEL_W16;
    else if (width_imm == IMM_W'(32)) wsel = SEL_W32;
    else if (width_imm == IMM_W'(64)) wsel = SEL_W64;
    else begin
      wsel      = SEL_BAD;
      bad_width = 1'b1;
    end
  end

  // 64-bit class: reverse always, order bit must be clear.
  // 32-bit class: reverse only when target order differs from host order.
  assign do_swap = cls64 ? 1'b1 : (order_bit != HOST_BIG);
  assign bad     = bad_width | (cls64 & order_bit);
endmodule

// File: rtl/bo_swapper.sv
module bo_swapper
  import bo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] operand,
  input  width_sel_e        wsel,
  input  logic              do_swap,
  input  logic              bad,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] cand [NUM_WIDTHS];

  for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
    localparam int LANES = 2 << k;
    logic [DATA_W-1:0] lane_v;

    always_comb begin
      lane_v = '0;
      for (int b = 0; b < LANES; b++) begin
        if (do_swap)
          lane_v[BYTE_W*b +: BYTE_W] = operand[BYTE_W*(LANES-1-b) +: BYTE_W];
        else
          lane_v[BYTE_W*b +: BYTE_W] = operand[BYTE_W*b +: BYTE_W];
      end
    end

    assign cand[k] = lane_v;
  end

  always_comb begin
    unique case (wsel)
      SEL_W16: value = cand[0];
      SEL_W32: value = cand[1];
      SEL_W64: value = cand[2];
      default: value = operand;
    endcase
    if (bad) value = operand;
  end
endmodule

// File: rtl/bo_out_stage.sv
module bo_out_stage #(
  parameter int W = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready = !full_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        full_q <= 1'b0;
    else if (in_ready) full_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) data_q <= in_data;
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
endmodule

// File: rtl/byte_order_unit.sv
module byte_order_unit
  import bo_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int IMM_W    = 32,
  parameter bit HOST_BIG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              cls64,
  input  logic              order_bit,
  input  logic [IMM_W-1:0]  width_imm,
  input  logic [DATA_W-1:0] operand,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  localparam int PAY_W = DATA_W + 1;

  width_sel_e        wsel;
  logic              do_swap;
  logic              bad;
  logic [DATA_W-1:0] value;
  logic [PAY_W-1:0]  pay_out;

  bo_decode #(.IMM_W(IMM_W), .HOST_BIG(HOST_BIG)) u_dec (
    .cls64     (cls64),
    .order_bit (order_bit),
    .width_imm (width_imm),
    .wsel      (wsel),
    .do_swap   (do_swap),
    .bad       (bad)
  );

  bo_swapper #(.DATA_W(DATA_W)) u_swp (
    .operand (operand),
    .wsel    (wsel),
    .do_swap (do_swap),
    .bad     (bad),
    .value   (value)
  );

  bo_out_stage #(.W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({bad, value}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign illegal = pay_out[DATA_W];
  assign result  = pay_out[DATA_W-1:0];
endmodule

// File: rtl/bo_checker.sv
module bo_checker #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              cls64,
  input logic              order_bit,
  input logic [IMM_W-1:0]  width_imm,
  input logic [DATA_W-1:0] operand,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);
  logic take;
  logic legal_w;
  assign take    = in_valid && in_ready;
  assign legal_w = (width_imm == IMM_W'(16)) || (width_imm == IMM_W'(32)) ||
                   (width_imm == IMM_W'(64));

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(illegal)));

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  drain_admits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);

  // R9
  idle_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !take) |=> !out_valid);

  // R5
  bad_width_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !legal_w) |=> (illegal && result == $past(operand)));

  // R6
  bad_order_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls64 && order_bit) |=> (illegal && result == $past(operand)));

  // R1
  wide_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls64 && !order_bit && width_imm == IMM_W'(64)) |=>
      (!illegal && result[DATA_W-1 -: 8] == $past(operand[7:0]) &&
       result[7:0] == $past(operand[DATA_W-1 -: 8])));

  // R4
  narrow_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !order_bit && width_imm == IMM_W'(16)) |=>
      (result[DATA_W-1:16] == '0));
endmodule

bind byte_order_unit bo_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .cls64     (cls64),
  .order_bit (order_bit),
  .width_imm (width_imm),
  .operand   (operand),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/byte_order_unit_test.sv
`timescale 1ns/1ps
module byte_order_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        cls64 = 1'b0;
  logic        order_bit = 1'b0;
  logic [31:0] width_imm = 32'd0;
  logic [63:0] operand = '0;
  logic        out_ready = 1'b1;
  logic        in_ready_le, in_ready_be, out_valid_le, out_valid_be;
  logic        illegal_le, illegal_be;
  logic [63:0] result_le, result_be;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byte_order_unit #(.HOST_BIG(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_le),
    .cls64(cls64), .order_bit(order_bit), .width_imm(width_imm), .operand(operand),
    .out_valid(out_valid_le), .out_ready(out_ready), .result(result_le),
    .illegal(illegal_le));

  byte_order_unit #(.HOST_BIG(1'b1)) uut_be (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_be),
    .cls64(cls64), .order_bit(order_bit), .width_imm(width_imm), .operand(operand),
    .out_valid(out_valid_be), .out_ready(out_ready), .result(result_be),
    .illegal(illegal_be));

  function automatic logic [64:0] model(logic w64, logic ob, logic [31:0] imm,
                                        logic [63:0] op, logic host_big);
    logic [63:0] r;
    int n;
    logic sw;
    if (!(imm == 16 || imm == 32 || imm == 64) || (w64 && ob)) return {1'b1, op};
    n  = int'(imm) / 8;
    sw = w64 ? 1'b1 : (ob != host_big);
    r  = '0;
    for (int i = 0; i < n; i++) begin
      if (sw) r[8*(n-1-i) +: 8] = op[8*i +: 8];
      else    r[8*i +: 8]       = op[8*i +: 8];
    end
    return {1'b0, r};
  endfunction

  task automatic check(string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(logic w64, logic ob, logic [31:0] imm, logic [63:0] op);
    @(negedge clk);
    cls64 = w64; order_bit = ob; width_imm = imm; operand = op; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic op_check(string tag, logic w64, logic ob, logic [31:0] imm,
                          logic [63:0] op);
    send(w64, ob, imm, op);
    check({tag, " valid"}, {64'd0, out_valid_le & out_valid_be}, 65'd1);
    check({tag, " le-host"}, {illegal_le, result_le}, model(w64, ob, imm, op, 1'b0));
    check({tag, " be-host"}, {illegal_be, result_be}, model(w64, ob, imm, op, 1'b1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 out_valid after reset", {64'd0, out_valid_le | out_valid_be}, 65'd0);
    check("R9 in_ready after reset", {64'd0, in_ready_le & in_ready_be}, 65'd1);
    repeat (2) @(negedge clk);
    check("R9 stays empty", {64'd0, out_valid_le | out_valid_be}, 65'd0);
  endtask

  task automatic t_wide();
    op_check("R1 wide 64", 1'b1, 1'b0, 32'd64, 64'h0102030405060708);
    op_check("R1 wide 32", 1'b1, 1'b0, 32'd32, 64'hAABBCCDD11223344);
    op_check("R1 wide 16", 1'b1, 1'b0, 32'd16, 64'hFFFFFFFFFFFF1234);
    check("R1 explicit", {illegal_le, result_le}, {1'b0, 64'h3412});
  endtask

  task automatic t_narrow();
    op_check("R2 to-little 32", 1'b0, 1'b0, 32'd32, 64'h1122334455667788);
    op_check("R2 to-big 32", 1'b0, 1'b1, 32'd32, 64'h1122334455667788);
    check("R2 explicit swap", {illegal_le, result_le}, {1'b0, 64'h88776655});
    check("R3 explicit keep", {illegal_be, result_be}, {1'b0, 64'h55667788});
    op_check("R2 to-big 64", 1'b0, 1'b1, 32'd64, 64'h8000000000000001);
    op_check("R3 to-little 16", 1'b0, 1'b0, 32'd16, 64'hDEADBEEFCAFEF00D);
    check("R4 zero above 16", {1'b0, result_le[63:16]}, 65'd0);
  endtask

  task automatic t_illegal();
    op_check("R5 width 8", 1'b0, 1'b0, 32'd8, 64'h0123456789ABCDEF);
    op_check("R5 width 48", 1'b1, 1'b0, 32'd48, 64'hFEDCBA9876543210);
    op_check("R5 width big", 1'b0, 1'b1, 32'h0001_0010, 64'h5555AAAA5555AAAA);
    op_check("R6 wide order set", 1'b1, 1'b1, 32'd64, 64'h0011223344556677);
    check("R6 explicit", {illegal_le, result_le}, {1'b1, 64'h0011223344556677});
  endtask

  task automatic t_backpressure();
    logic [63:0] a = 64'h0A0B0C0D0E0F1011;
    logic [63:0] b = 64'h2122232425262728;
    @(negedge clk);
    out_ready = 1'b0;
    send(1'b1, 1'b0, 32'd64, a);
    check("R7 first valid", {64'd0, out_valid_le}, 65'd1);
    @(negedge clk);
    cls64 = 1'b1; order_bit = 1'b0; width_imm = 32'd64; operand = b; in_valid = 1'b1;
    #1;
    check("R8 in_ready low", {64'd0, in_ready_le | in_ready_be}, 65'd0);
    repeat (3) @(negedge clk);
    check("R8 held", {illegal_le, result_le}, model(1'b1, 1'b0, 32'd64, a, 1'b0));
    check("R8 still valid", {64'd0, out_valid_le}, 65'd1);
    out_ready = 1'b1;
    #1;
    check("R10 in_ready while draining", {64'd0, in_ready_le & in_ready_be}, 65'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next accepted", {illegal_le, result_le}, model(1'b1, 1'b0, 32'd64, b, 1'b0));
    check("R7 valid after swap-in", {64'd0, out_valid_le}, 65'd1);
    @(negedge clk);
    check("R9 empties", {64'd0, out_valid_le}, 65'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide();
    t_narrow();
    t_illegal();
    t_backpressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule